// File: doc/BRIEF.md
# Nonvolatile Byte Memory Array Model

This block is a clocked, synthesizable model of a byte-wide nonvolatile RAM. It has an SRAM-style control interface. Thirteen address lines select one of 8192 bytes. The data bus is split into an input, an output and an output-enable, which the chip level combines into a bidirectional pad. Control pins are sampled on the rising edge of the system clock, and read data appears one cycle later. A write lands on the edge where it is sampled, so there is no busy or polling state, and a read on the next cycle returns the new byte.

A mode input stands in for a raised pin level and switches accesses to a 64-entry identification space. Six address bits form the index into that space. Entry 0 and entry 1 hold fixed identification codes, and the other 62 entries are user bytes. After reset, an initialisation sweep sets every stored bit to one. A power-good input blocks all access while it is low. After power-good returns, and after the mode input drops, access resumes only once a recovery delay has elapsed. Each delay is a parameter counted in clock cycles.

Top module: `nvram_byte_top`

## Requirements
- R1: The main array holds 8192 bytes addressed by `addr[12:0]`. A byte written at one edge is returned by a read presented at the very next edge, with no wait state.
- R2: A read request is sampled when `we_n`=1, `ce1_n`=0, `ce2`=1 and `oe_n`=0. When access is permitted, `dq_oe` is 1 one cycle after such a request. It is 0 one cycle after any other combination of these pins.
- R3: A write happens at every edge where `ce1_n`=0, `ce2`=1 and `we_n`=0, so the last edge of a write window decides the stored byte. With `ce1_n`=1 or `ce2`=0 the byte is left unchanged.
- R4: When `we_n`=0 is sampled, `dq_oe` is 0 in the following cycle, even if `oe_n` is 0 and the chip is selected.
- R5: After `rst`, a sweep of 2^ADDR_W cycles sets every main-array byte and every user identification byte to FFh. No access takes effect during the sweep.
- R6: While `id_mode`=1, the identification index is {addr[6], addr[5], addr[4], addr[12], addr[11], addr[10]} with addr[6] as the MSB. All other address bits are ignored.
- R7: Identification entry 00h always reads 34h and entry 01h always reads 41h. Writes to either entry are discarded. Entries 02h to 3Fh can be read and written.
- R8: While `pwr_good`=0 is sampled, writes are ignored and `dq_oe` is 0 in the following cycle.
- R9: After `pwr_good` returns high, the first PWR_RECOVER_CYC edges with `pwr_good`=1 are ignored.
- R10: After `id_mode` is sampled 0 following a sampled 1, main-array accesses at the first ID_EXIT_CYC edges are ignored. Writes made in identification mode never change the main array.
- R11: `dq_out` reads 00h whenever `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; starts the initialisation sweep |
| addr | input | 13 | Byte address; also supplies the identification index |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, 00h when not driving |
| dq_oe | output | 1 | Drive enable for the data pad |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| id_mode | input | 1 | Selects the identification space |
| pwr_good | input | 1 | Supply-valid indication; low blocks all access |

## Verification
A write is due at the same edge that samples it. A read result (`dq_oe` and `dq_out`) is due exactly one edge after its request, so the bench drives pins on falling edges and checks results on the next falling edge. A behavioural reference model updates on every rising edge and is compared with the outputs on every falling edge. The two hold-off windows are checked edge by edge. After a read request is held across the return of `pwr_good` (or the drop of `id_mode`), the output must stay off for exactly PWR_RECOVER_CYC (or ID_EXIT_CYC) cycles and then show the stored byte on the next cycle. The sweep is checked by probing during it and then reading FFh once it has finished.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

    typedef enum logic [1:0] {
        GS_INIT = 2'd0,
        GS_WAIT = 2'd1,
        GS_RUN  = 2'd2
    } gate_st_e;

    localparam logic [7:0] ID_MFG_VAL = 8'h34;
    localparam logic [7:0] ID_DEV_VAL = 8'h41;
    localparam int         ID_IDX_W   = 6;

    // Identification index: fixed pin order, MSB first.
    function automatic logic [ID_IDX_W-1:0] id_index(input logic [12:0] a);
        return {a[6], a[5], a[4], a[12], a[11], a[10]};
    endfunction

endpackage

// File: rtl/nvr_gate.sv
module nvr_gate
    import nvr_pkg::*;
#(
    parameter int AW              = 13,
    parameter int PWR_RECOVER_CYC = 1000,
    parameter int ID_EXIT_CYC     = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_good,
    input  logic          id_mode,
    output logic          arr_ok,
    output logic          id_ok,
    output logic          sweep_en,
    output logic [AW-1:0] sweep_addr
);
    localparam int DEPTH = 1 << AW;
    localparam int PCW   = $clog2(PWR_RECOVER_CYC + 1);
    localparam int XCW   = $clog2(ID_EXIT_CYC + 1);

    typedef struct packed {
        gate_st_e       st;
        logic [AW-1:0]  sweep;
        logic [PCW-1:0] pcnt;
        logic [XCW-1:0] xcnt;
        logic           id_prev;
    } gate_t;

    localparam gate_t GATE_RST = '{st: GS_INIT, sweep: '0, pcnt: '0, xcnt: '0, id_prev: 1'b0};

    gate_t gate_d, gate_q;
    logic  exit_edge;
    logic  running;

    always_comb begin
        gate_d         = gate_q;
        gate_d.id_prev = id_mode;
        exit_edge      = gate_q.id_prev && !id_mode;

        if (exit_edge) begin
            gate_d.xcnt = XCW'(ID_EXIT_CYC - 1);
        end else if (gate_q.xcnt != '0) begin
            gate_d.xcnt = gate_q.xcnt - 1'b1;
        end

        unique case (gate_q.st)
            GS_INIT: begin
                gate_d.sweep = gate_q.sweep + 1'b1;
                gate_d.pcnt  = '0;
                if (gate_q.sweep == AW'(DEPTH - 1)) begin
                    gate_d.st = pwr_good ? GS_RUN : GS_WAIT;
                end
            end
            GS_WAIT: begin
                if (!pwr_good) begin
                    gate_d.pcnt = '0;
                end else if (gate_q.pcnt == PCW'(PWR_RECOVER_CYC - 1)) begin
                    gate_d.st   = GS_RUN;
                    gate_d.pcnt = '0;
                end else begin
                    gate_d.pcnt = gate_q.pcnt + 1'b1;
                end
            end
            default: begin
                if (!pwr_good) begin
                    gate_d.st   = GS_WAIT;
                    gate_d.pcnt = '0;
                end
            end
        endcase

        running    = (gate_q.st == GS_RUN) && pwr_good;
        id_ok      = running && id_mode;
        arr_ok     = running && !id_mode && !exit_edge && (gate_q.xcnt == '0);
        sweep_en   = (gate_q.st == GS_INIT);
        sweep_addr = gate_q.sweep;
    end

    always_ff @(posedge clk) begin
        if (rst) gate_q <= GATE_RST;
        else     gate_q <= gate_d;
    end

    AST_SWEEP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        sweep_en |-> (!arr_ok && !id_ok)); // R5
    AST_RECOVER_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good) |-> (!arr_ok && !id_ok)); // R9
    AST_EXIT_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        $fell(id_mode) |-> !arr_ok); // R10

endmodule

// File: rtl/nvr_array.sv
module nvr_array #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          sweep_en,
    input  logic [AW-1:0] sweep_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          w_go;
    logic [AW-1:0] w_a;
    logic [DW-1:0] w_d;
    logic [DW-1:0] rd_d, rd_q;

    // The sweep owns the write port while it runs.
    always_comb begin
        w_go    = sweep_en || wr_en;
        w_a     = sweep_en ? sweep_addr : waddr;
        w_d     = sweep_en ? '1 : wdata;
        rd_d    = mem[raddr];
        rd_data = rd_q;
    end

    // Storage carries no reset so it maps onto a plain RAM.
    always_ff @(posedge clk) begin
        if (w_go) mem[w_a] <= w_d;
        rd_q <= rd_d;
    end

endmodule

// File: rtl/nvr_idspace.sv
module nvr_idspace
    import nvr_pkg::*;
#(
    parameter int DW = 8,
    parameter int IW = ID_IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data
);
    localparam int ID_N    = 1 << IW;
    localparam int USER_LO = 2;

    logic [DW-1:0] user_d [USER_LO:ID_N-1];
    logic [DW-1:0] user_q [USER_LO:ID_N-1];
    logic [DW-1:0] rd_d, rd_q;

    always_comb begin
        for (int i = USER_LO; i < ID_N; i++) user_d[i] = user_q[i];
        if (wr_en && (idx >= IW'(USER_LO))) user_d[idx] = wdata;

        if (idx == IW'(0))      rd_d = DW'(ID_MFG_VAL);
        else if (idx == IW'(1)) rd_d = DW'(ID_DEV_VAL);
        else                    rd_d = user_q[idx];
        rd_data = rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = USER_LO; i < ID_N; i++) user_q[i] <= '1;
            rd_q <= '0;
        end else begin
            for (int i = USER_LO; i < ID_N; i++) user_q[i] <= user_d[i];
            rd_q <= rd_d;
        end
    end

    AST_MFG_FIXED: assert property (@(posedge clk) disable iff (rst)
        (idx == IW'(0)) |=> (rd_data == DW'(ID_MFG_VAL))); // R7
    AST_DEV_FIXED: assert property (@(posedge clk) disable iff (rst)
        (idx == IW'(1)) |=> (rd_data == DW'(ID_DEV_VAL))); // R7

endmodule

// File: rtl/nvram_byte_top.sv
module nvram_byte_top
    import nvr_pkg::*;
#(
    parameter int ADDR_W          = 13,
    parameter int DATA_W          = 8,
    parameter int PWR_RECOVER_CYC = 1000,
    parameter int ID_EXIT_CYC     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              id_mode,
    input  logic              pwr_good
);
    typedef struct packed {
        logic oe;
        logic src_id;
    } bus_t;

    bus_t                bus_d, bus_q;
    logic                sel, wr_req, rd_req;
    logic                arr_ok, id_ok;
    logic                sweep_en;
    logic [ADDR_W-1:0]   sweep_addr;
    logic [ID_IDX_W-1:0] idx;
    logic [DATA_W-1:0]   arr_rd, id_rd;

    nvr_gate #(
        .AW              (ADDR_W),
        .PWR_RECOVER_CYC (PWR_RECOVER_CYC),
        .ID_EXIT_CYC     (ID_EXIT_CYC)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .pwr_good   (pwr_good),
        .id_mode    (id_mode),
        .arr_ok     (arr_ok),
        .id_ok      (id_ok),
        .sweep_en   (sweep_en),
        .sweep_addr (sweep_addr)
    );

    nvr_array #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_array (
        .clk        (clk),
        .sweep_en   (sweep_en),
        .sweep_addr (sweep_addr),
        .wr_en      (wr_req && arr_ok),
        .waddr      (addr),
        .wdata      (dq_in),
        .raddr      (addr),
        .rd_data    (arr_rd)
    );

    nvr_idspace #(
        .DW (DATA_W),
        .IW (ID_IDX_W)
    ) u_idspace (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_req && id_ok),
        .idx     (idx),
        .wdata   (dq_in),
        .rd_data (id_rd)
    );

    always_comb begin
        sel    = !ce1_n && ce2;
        wr_req = sel && !we_n;
        rd_req = sel && we_n && !oe_n;
        idx    = id_index(addr[12:0]);

        bus_d.oe     = rd_req && (arr_ok || id_ok);
        bus_d.src_id = id_ok;

        dq_oe  = bus_q.oe;
        dq_out = bus_q.oe ? (bus_q.src_id ? id_rd : arr_rd) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) bus_q <= '0;
        else     bus_q <= bus_d;
    end

    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !dq_oe); // R2
    AST_WE_DROPS_OE: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> !dq_oe); // R4
    AST_PWR_DROPS_OE: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> !dq_oe); // R8

endmodule

// File: tb/nvram_byte_top_tb.sv
module nvram_byte_top_tb;
    localparam int AW     = 13;
    localparam int DEPTH  = 1 << AW;
    localparam int N_PWR  = 1000;
    localparam int N_EXIT = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic        ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic        id_mode = 1'b0, pwr_good = 1'b1;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    nvram_byte_top #(
        .ADDR_W(AW), .DATA_W(8), .PWR_RECOVER_CYC(N_PWR), .ID_EXIT_CYC(N_EXIT)
    ) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
        .id_mode(id_mode), .pwr_good(pwr_good)
    );

    // Behavioural reference model
    logic [7:0] m_mem [DEPTH];
    logic [7:0] m_id  [64];
    int         m_edges, m_recov, m_exit;
    bit         m_id_prev, m_run, m_blk, m_aok, m_iok, m_rd, m_wr;
    logic [5:0] m_idx;
    bit         exp_oe;
    logic [7:0] exp_dat;

    function automatic logic [7:0] id_val(input logic [5:0] i);
        if (i == 6'd0) return 8'h34;
        if (i == 6'd1) return 8'h41;
        return m_id[i];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_edges = 0; m_recov = 0; m_exit = 0; m_id_prev = 0;
            exp_oe = 0; exp_dat = 8'h00;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
            for (int i = 0; i < 64; i++) m_id[i] = 8'hFF;
        end else begin
            if (m_edges < DEPTH) begin
                m_run = 0; m_edges++;
            end else if (!pwr_good) begin
                m_run = 0; m_recov = N_PWR;
            end else if (m_recov > 0) begin
                m_run = 0; m_recov--;
            end else m_run = 1;
            m_blk = 0;
            if (m_id_prev && !id_mode) begin
                m_blk = 1; m_exit = N_EXIT - 1;
            end else if (m_exit > 0) begin
                m_blk = 1; m_exit--;
            end
            m_id_prev = id_mode;
            m_aok = m_run && !id_mode && !m_blk;
            m_iok = m_run && id_mode;
            m_idx = {addr[6], addr[5], addr[4], addr[12], addr[11], addr[10]};
            m_rd  = !ce1_n && ce2 && we_n && !oe_n;
            m_wr  = !ce1_n && ce2 && !we_n;
            exp_oe  = m_rd && (m_aok || m_iok);
            exp_dat = !exp_oe ? 8'h00 : (m_iok ? id_val(m_idx) : m_mem[addr]);
            if (m_wr && m_aok) m_mem[addr] = dq_in;
            if (m_wr && m_iok && m_idx >= 6'd2) m_id[m_idx] = dq_in;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            tests++;
            if (dq_oe !== exp_oe || dq_out !== exp_dat) begin
                fails++;
                $display("FAIL R2 R11 model compare t=%0t: got oe=%0b data=%h, expected oe=%0b data=%h",
                         $time, dq_oe, dq_out, exp_oe, exp_dat);
            end
        end
    end

    task automatic check(input bit e_en, input logic [7:0] e_d, input string tag);
        logic [7:0] want;
        want = e_en ? e_d : 8'h00;
        tests++;
        if (dq_oe !== e_en || dq_out !== want) begin
            fails++;
            $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                     tag, dq_oe, dq_out, e_en, want);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; dq_in = d; ce1_n = 0; ce2 = 1; we_n = 0; oe_n = 1;
    endtask

    task automatic rd_chk(input logic [12:0] a, input logic [7:0] d, input bit en, input string tag);
        @(negedge clk);
        addr = a; ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 0;
        @(negedge clk);
        check(en, d, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        ce1_n = 1; ce2 = 0; we_n = 1; oe_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(0, 8'h00, "R5 reset state");
        rst = 0;
        repeat (100) @(negedge clk);
        rd_chk(13'h0010, 8'h00, 0, "R5 no access during sweep");
        idle();
        repeat (DEPTH) @(negedge clk);

        rd_chk(13'h0000, 8'hFF, 1, "R5 array low byte FF");
        rd_chk(13'h1FFF, 8'hFF, 1, "R5 array top byte FF");
        rd_chk(13'h1234, 8'hFF, 1, "R5 array mid byte FF");

        wr(13'h0000, 8'hA5);
        rd_chk(13'h0000, 8'hA5, 1, "R1 read right after write");
        wr(13'h1FFF, 8'h3C);
        rd_chk(13'h1FFF, 8'h3C, 1, "R1 top address");
        wr(13'h0100, 8'h11);
        wr(13'h0100, 8'h22);
        rd_chk(13'h0100, 8'h22, 1, "R3 last write of window");

        @(negedge clk); addr = 13'h0100; dq_in = 8'h77; ce1_n = 0; ce2 = 0; we_n = 0; oe_n = 1;
        @(negedge clk); ce1_n = 1; ce2 = 1;
        rd_chk(13'h0100, 8'h22, 1, "R3 deselected write ignored");

        @(negedge clk); addr = 13'h0100; ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 1;
        @(negedge clk); check(0, 8'h00, "R2 oe_n high no drive");
        ce2 = 0; oe_n = 0;
        @(negedge clk); check(0, 8'h00, "R2 ce2 low no drive");

        rd_chk(13'h0200, 8'hFF, 1, "R2 read before write");
        we_n = 0; dq_in = 8'h99;
        @(negedge clk); check(0, 8'h00, "R4 we low turns outputs off");
        rd_chk(13'h0200, 8'h99, 1, "R4 write with oe low landed");

        idle();
        @(negedge clk); id_mode = 1;
        rd_chk(13'h0000, 8'h34, 1, "R7 entry 00h");
        rd_chk(13'h0400, 8'h41, 1, "R6 addr10 is index LSB");
        rd_chk(13'h0040, 8'hFF, 1, "R5 user id byte FF");
        wr(13'h004F, 8'hC3);
        rd_chk(13'h0040, 8'hC3, 1, "R6 low address bits ignored");
        wr(13'h0000, 8'h00);
        rd_chk(13'h0000, 8'h34, 1, "R7 entry 00h write discarded");
        wr(13'h0400, 8'h00);
        rd_chk(13'h0400, 8'h41, 1, "R7 entry 01h write discarded");
        wr(13'h1000, 8'h4D);
        rd_chk(13'h1080, 8'h4D, 1, "R6 addr12 maps to index bit2");

        @(negedge clk);
        id_mode = 0; addr = 13'h0000; ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 0;
        for (int k = 1; k <= N_EXIT; k++) begin
            @(negedge clk); check(0, 8'h00, "R10 exit hold-off");
        end
        @(negedge clk); check(1, 8'hA5, "R10 access after exit delay");
        rd_chk(13'h1000, 8'hFF, 1, "R10 id write left array alone");

        @(negedge clk); pwr_good = 0;
        wr(13'h0000, 8'hEE);
        rd_chk(13'h0000, 8'h00, 0, "R8 no drive while power low");
        @(negedge clk);
        pwr_good = 1; addr = 13'h0000; ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 0;
        for (int k = 1; k <= N_PWR; k++) begin
            @(negedge clk); if (k == 1 || k == N_PWR) check(0, 8'h00, "R9 recovery hold-off");
        end
        @(negedge clk); check(1, 8'hA5, "R9 R8 access resumes, low-power write ignored");
        idle();
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule